// File: doc/BRIEF.md
# Decimal Character Code Converter

This block converts between a binary accumulator value and a string of ten decimal digit codes. It works on a register pair, A and X. Each word of the pair is a sign bit over five 6-bit bytes, so each word has a 30-bit magnitude. In numeric mode the ten bytes of A:X are read as decimal digits. A is the high half, and within each word byte 1 is the most significant. Their binary value is written into the magnitude of A. In character mode the magnitude of A is written out as ten decimal digit codes across the ten bytes of A:X.

An operation is started with a one-cycle `start` pulse that carries the mode, both words and the incoming overflow flag. The block then works one digit per clock. It raises `done` for one cycle when the result words and overflow flag are valid on its outputs. The outputs hold that result until the next operation completes. Neither mode takes an address or memory operand.

Top module: `dec_char_conv`

## Requirements
- R1: After reset `done` is 0 and `a_out`, `x_out` and `ovf_out` are all zero.
- R2: With `mode`=0 (numeric), the ten bytes are taken in order: A bytes 1..5 (A byte 1 = bits 29:24), then X bytes 1..5. Each byte supplies the digit (byte value mod 10), so 0, 10, ..., 60 all give 0. The magnitude of `a_out` (bits 29:0) becomes the decimal value of these ten digits, most significant first.
- R3: In numeric mode the magnitude of `x_out` equals the magnitude of `x_in`. The sign bits (bit 30) of both words are copied from the inputs unchanged.
- R4: In numeric mode, when the decimal value exceeds 1,073,741,823, `ovf_out` is 1 and the magnitude of `a_out` is the value modulo 2^30.
- R5: `ovf_out` equals `ovf_in` OR the overflow detected by the operation. A set incoming flag is never cleared, and in character mode `ovf_out` equals `ovf_in`.
- R6: With `mode`=1 (character), the magnitude of `a_in` is written as exactly ten decimal digits with leading zeros, and digit d is coded as byte value 30+d. The five high-order codes fill A bytes 1..5 and the five low-order codes fill X bytes 1..5, most significant first.
- R7: In character mode the sign bits of both words are copied from the inputs unchanged.
- R8: `done` is a single-cycle pulse that becomes visible after the 10th rising clock edge following the edge that samples `start`. The output words and flag change only at that edge.
- R9: A `start` received while an operation is in progress is ignored. The running operation finishes on time with its original inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins an operation when the block is idle |
| mode | input | 1 | 0 = digits to binary, 1 = binary to digit codes |
| a_in | input | 31 | Word A: bit 30 sign, bits 29:0 five bytes |
| x_in | input | 31 | Word X: bit 30 sign, bits 29:0 five bytes |
| ovf_in | input | 1 | Incoming overflow flag |
| done | output | 1 | One-cycle pulse when results are valid |
| a_out | output | 31 | Result word A |
| x_out | output | 31 | Result word X |
| ovf_out | output | 1 | Resulting overflow flag |

## Verification
Every result, including both words and the overflow flag, is due together. It arrives after the tenth rising edge following the edge that samples `start`, and it stays valid after `done` drops. The bench drives the start pulse at a falling edge and then counts falling edges until `done` is seen. It treats any count other than ten as a failure. Results are compared at that falling edge, and compared again one falling edge later, to confirm that `done` has dropped and the words are held. Runs that re-pulse `start` mid-operation use the same count, so a restart would show up both as a wrong latency and as a wrong result.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
    parameter int BYTE_BITS  = 6;
    parameter int WORD_BYTES = 5;
    parameter int DIGIT_BASE = 30;

    typedef enum logic {
        CVT_TO_BIN  = 1'b0,
        CVT_TO_CHAR = 1'b1
    } cvt_mode_e;
endpackage

// File: rtl/dcc_num_step.sv
module dcc_num_step #(
    parameter int BYTE_W = 6,
    parameter int ACC_W  = 35
) (
    input  logic [ACC_W-1:0]  acc_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [ACC_W-1:0]  acc_o
);
    logic [BYTE_W-1:0] digit;

    always_comb begin
        digit = byte_i % BYTE_W'(10);
        acc_o = (acc_i << 3) + (acc_i << 1) + ACC_W'(digit);
    end
endmodule

// File: rtl/dcc_chr_step.sv
module dcc_chr_step #(
    parameter int BYTE_W = 6,
    parameter int MAG_W  = 30,
    parameter int BASE   = 30
) (
    input  logic [MAG_W-1:0]  val_i,
    output logic [MAG_W-1:0]  quo_o,
    output logic [BYTE_W-1:0] code_o
);
    logic [MAG_W-1:0] rem_w;

    always_comb begin
        quo_o  = val_i / MAG_W'(10);
        rem_w  = val_i - (quo_o << 3) - (quo_o << 1);
        code_o = BYTE_W'(BASE) + rem_w[BYTE_W-1:0];
    end
endmodule

// File: rtl/dec_char_conv.sv
module dec_char_conv
    import dcc_pkg::*;
#(
    parameter int BYTE_W     = dcc_pkg::BYTE_BITS,
    parameter int WORD_BYTES = dcc_pkg::WORD_BYTES,
    parameter int CHAR_BASE  = dcc_pkg::DIGIT_BASE
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic                              mode,
    input  logic [BYTE_W*WORD_BYTES:0]        a_in,
    input  logic [BYTE_W*WORD_BYTES:0]        x_in,
    input  logic                              ovf_in,
    output logic                              done,
    output logic [BYTE_W*WORD_BYTES:0]        a_out,
    output logic [BYTE_W*WORD_BYTES:0]        x_out,
    output logic                              ovf_out
);
    localparam int MAG_W  = BYTE_W * WORD_BYTES;
    localparam int WORD_W = MAG_W + 1;
    localparam int DIGITS = 2 * WORD_BYTES;
    localparam int STR_W  = 2 * MAG_W;
    localparam int ACC_W  = 7 * WORD_BYTES;
    localparam int CNT_W  = $clog2(DIGITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIGITS - 1);

    typedef struct packed {
        logic              busy;
        cvt_mode_e         mode;
        logic [CNT_W-1:0]  cnt;
        logic [STR_W-1:0]  str;
        logic [ACC_W-1:0]  acc;
        logic [MAG_W-1:0]  xmag;
        logic              sa;
        logic              sx;
        logic              ovf_lat;
        logic              done;
        logic [WORD_W-1:0] a_out;
        logic [WORD_W-1:0] x_out;
        logic              ovf_out;
    } st_t;

    st_t st_d, st_q;

    logic [ACC_W-1:0]  num_acc;
    logic [MAG_W-1:0]  chr_quo;
    logic [BYTE_W-1:0] chr_code;
    logic [STR_W-1:0]  chr_str;
    logic              num_ovf;

    dcc_num_step #(.BYTE_W(BYTE_W), .ACC_W(ACC_W)) u_num (
        .acc_i  (st_q.acc),
        .byte_i (st_q.str[STR_W-1 -: BYTE_W]),
        .acc_o  (num_acc)
    );

    dcc_chr_step #(.BYTE_W(BYTE_W), .MAG_W(MAG_W), .BASE(CHAR_BASE)) u_chr (
        .val_i  (st_q.acc[MAG_W-1:0]),
        .quo_o  (chr_quo),
        .code_o (chr_code)
    );

    always_comb begin
        st_d     = st_q;
        st_d.done = 1'b0;
        chr_str  = {chr_code, st_q.str[STR_W-1:BYTE_W]};
        num_ovf  = |num_acc[ACC_W-1:MAG_W];
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy    = 1'b1;
                st_d.mode    = cvt_mode_e'(mode);
                st_d.cnt     = '0;
                st_d.sa      = a_in[WORD_W-1];
                st_d.sx      = x_in[WORD_W-1];
                st_d.xmag    = x_in[MAG_W-1:0];
                st_d.ovf_lat = ovf_in;
                if (mode == CVT_TO_CHAR) begin
                    st_d.acc = ACC_W'(a_in[MAG_W-1:0]);
                    st_d.str = '0;
                end else begin
                    st_d.acc = '0;
                    st_d.str = {a_in[MAG_W-1:0], x_in[MAG_W-1:0]};
                end
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.mode == CVT_TO_CHAR) begin
                st_d.acc = ACC_W'(chr_quo);
                st_d.str = chr_str;
            end else begin
                st_d.acc = num_acc;
                st_d.str = st_q.str << BYTE_W;
            end
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                if (st_q.mode == CVT_TO_CHAR) begin
                    st_d.a_out   = {st_q.sa, chr_str[STR_W-1:MAG_W]};
                    st_d.x_out   = {st_q.sx, chr_str[MAG_W-1:0]};
                    st_d.ovf_out = st_q.ovf_lat;
                end else begin
                    st_d.a_out   = {st_q.sa, num_acc[MAG_W-1:0]};
                    st_d.x_out   = {st_q.sx, st_q.xmag};
                    st_d.ovf_out = st_q.ovf_lat | num_ovf;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done    = st_q.done;
    assign a_out   = st_q.a_out;
    assign x_out   = st_q.x_out;
    assign ovf_out = st_q.ovf_out;

    function automatic logic codes_ok(input logic [MAG_W-1:0] m);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < WORD_BYTES; i++) begin
            if (m[i*BYTE_W +: BYTE_W] < BYTE_W'(CHAR_BASE) ||
                m[i*BYTE_W +: BYTE_W] > BYTE_W'(CHAR_BASE + 9))
                ok = 1'b0;
        end
        return ok;
    endfunction

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_hold_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(a_out) && $stable(x_out) && $stable(ovf_out)));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && start && st_q.cnt != LAST) |=>
            (st_q.busy && st_q.cnt == $past(st_q.cnt) + 1'b1));

    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && st_q.ovf_lat) |-> ovf_out);

    assert_signs_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (a_out[WORD_W-1] == st_q.sa && x_out[WORD_W-1] == st_q.sx));

    assert_char_codes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && st_q.mode == CVT_TO_CHAR) |->
            (codes_ok(a_out[MAG_W-1:0]) && codes_ok(x_out[MAG_W-1:0])));
endmodule

// File: tb/sim_dec_char_conv.sv
module sim_dec_char_conv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic [30:0] a_in = '0;
    logic [30:0] x_in = '0;
    logic        ovf_in = 1'b0;
    logic        done;
    logic [30:0] a_out;
    logic [30:0] x_out;
    logic        ovf_out;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] lfsr = 32'hACE1_2357;

    always #5 clk = ~clk;

    dec_char_conv u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .a_in(a_in), .x_in(x_in), .ovf_in(ovf_in),
        .done(done), .a_out(a_out), .x_out(x_out), .ovf_out(ovf_out)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    task automatic run(input logic m, input logic [30:0] a, input logic [30:0] x,
                       input logic ov, input bit poke);
        longint val;
        logic [59:0] str;
        logic [30:0] ea, ex;
        logic eo;
        int n;
        if (m == 1'b0) begin
            str = {a[29:0], x[29:0]};
            val = 0;
            for (int i = 0; i < 10; i++)
                val = val * 10 + longint'((str >> (54 - 6 * i)) & 60'h3F) % 10;
            ea = {a[30], 30'(val)};
            ex = x;
            eo = ov | (val > 64'd1073741823);
        end else begin
            val = longint'(a[29:0]);
            str = '0;
            for (int i = 0; i < 10; i++) begin
                str[6*i +: 6] = 6'(30 + val % 10);
                val = val / 10;
            end
            ea = {a[30], str[59:30]};
            ex = {x[30], str[29:0]};
            eo = ov;
        end
        @(negedge clk);
        start = 1'b1; mode = m; a_in = a; x_in = x; ovf_in = ov;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 40) begin
            if (poke && n == 3) begin
                start = 1'b1; mode = ~m; a_in = ~a; x_in = ~x; ovf_in = ~ov;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        chk(n == 10, poke ? "R9 latency with restart" : "R8 latency", n, 10);
        if (m == 1'b0) begin
            chk(a_out[29:0] == ea[29:0], poke ? "R9 numeric A" : "R2/R4 numeric A", a_out, ea);
            chk(x_out == ex && a_out[30] == ea[30], "R3 X and signs", {a_out[30], x_out}, {ea[30], ex});
            chk(ovf_out == eo, "R4/R5 overflow", ovf_out, eo);
        end else begin
            chk(a_out[29:0] == ea[29:0] && x_out[29:0] == ex[29:0],
                poke ? "R9 char codes" : "R6 char codes", {a_out, x_out}, {ea, ex});
            chk(a_out[30] == ea[30] && x_out[30] == ex[30], "R7 signs",
                {a_out[30], x_out[30]}, {ea[30], ex[30]});
            chk(ovf_out == eo, "R5 char overflow passthrough", ovf_out, eo);
        end
        @(negedge clk);
        chk(!done, "R8 done single pulse", done, 0);
        chk(a_out == ea && ovf_out == eo, "R8 outputs held", a_out, ea);
    endtask

    function automatic logic [29:0] digits_to_bytes(input logic [3:0] d [10], input int lo);
        logic [29:0] w;
        for (int i = 0; i < 5; i++)
            w[24 - 6*i +: 6] = 6'(d[lo + i] + ((d[lo + i] < 4) ? 50 : 10 * (i % 3)));
        return w;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [3:0] dg [10];
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1 reset done", done, 0);
        chk(a_out == '0 && x_out == '0 && ovf_out == 1'b0, "R1 reset outputs", a_out, 0);
        rst_n = 1'b1;

        for (int p = 0; p < 10; p++)
            for (int v = 0; v < 64; v++) begin
                logic [59:0] s;
                s = 60'(v) << (54 - 6 * p);
                run(1'b0, {v[0], s[59:30]}, {v[1], s[29:0]}, 1'b0, 1'b0);
            end

        // limit 1073741823 then one above it, bytes carry tens offsets (R2, R4)
        dg = '{4'd1, 4'd0, 4'd7, 4'd3, 4'd7, 4'd4, 4'd1, 4'd8, 4'd2, 4'd3};
        run(1'b0, {1'b1, digits_to_bytes(dg, 0)}, {1'b0, digits_to_bytes(dg, 5)}, 1'b0, 1'b0);
        dg[9] = 4'd4;
        run(1'b0, {1'b0, digits_to_bytes(dg, 0)}, {1'b1, digits_to_bytes(dg, 5)}, 1'b0, 1'b0);
        dg = '{default: 4'd9};
        run(1'b0, {1'b1, digits_to_bytes(dg, 0)}, {1'b1, digits_to_bytes(dg, 5)}, 1'b0, 1'b0);
        run(1'b0, 31'h0, 31'h0, 1'b1, 1'b0);

        for (int k = 0; k < 200; k++) begin
            logic [30:0] ra, rx;
            lfsr = nxt(lfsr); ra = lfsr[30:0];
            lfsr = nxt(lfsr); rx = lfsr[30:0];
            lfsr = nxt(lfsr);
            run(1'b0, ra, rx, lfsr[5], k % 17 == 0);
        end

        run(1'b1, 31'h0, 31'h7FFF_FFFF, 1'b0, 1'b0);
        run(1'b1, {1'b1, 30'h3FFF_FFFF}, 31'h0, 1'b1, 1'b0);
        begin
            longint pw;
            pw = 1;
            for (int e = 0; e < 10; e++) begin
                run(1'b1, {e[0], 30'(pw)}, {e[1], 30'(pw + 7)}, e[2], 1'b0);
                run(1'b1, {1'b0, 30'(pw - 1)}, 31'h0, 1'b0, 1'b0);
                pw = pw * 10;
            end
        end
        for (int k = 0; k < 300; k++) begin
            logic [30:0] ra, rx;
            lfsr = nxt(lfsr); ra = lfsr[30:0];
            lfsr = nxt(lfsr); rx = lfsr[30:0];
            lfsr = nxt(lfsr);
            run(1'b1, ra, rx, lfsr[3], k % 13 == 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule